// File: doc/BRIEF.md
# LED Current Gradation Ramp Controller

This block moves the current-setting DAC code of an LED driver, one least significant bit at a time, from its present value toward a brightness target written by the register interface. The pace of the steps comes from a two-bit rate field, which scales a fixed prescaler period. A target can be rewritten at any moment. The code then turns from wherever it is toward the new value, and the step timer is not restarted.

A target of zero asks for shutdown. The code walks down to zero at the programmed pace. The boost converter is released only in the cycle the code reaches zero. While in shutdown, the first nonzero write turns the boost on before any upward step is taken.

The controller has four states. `RS_OFF` is shutdown, with the boost off and the step timer cleared. `RS_UP` means the code is below the target. `RS_DOWN` means the code is above a target. `RS_HOLD` means the code equals a nonzero target.

The transitions are:
- `RS_OFF` to `RS_UP` on a write of a nonzero target.
- Any active state to `RS_UP` or `RS_DOWN`, after a write or a step, whenever the next code is below or above the next target.
- Any active state to `RS_HOLD` when the next code equals a nonzero next target.
- Any active state to `RS_OFF` when the next code and the next target are both zero.

Top module: `ledramp_ctrl`

## Requirements
- R1: After reset `dac_code` is 0, `boost_en` is low and `shutdown` is high.
- R2: In shutdown, a write of a nonzero target raises `boost_en` and lowers `shutdown` at the clock edge that samples the write. `dac_code` stays 0 until the first step.
- R3: In shutdown, a write of zero has no effect on any output.
- R4: The step interval is `PRESCALE` × 2^`rate_sel` clocks, so `rate_sel` values 0, 1, 2 and 3 select 1, 2, 4 and 8 prescaler ticks. Steps fall on the edges at whole multiples of that interval after the edge that left shutdown.
- R5: Each step changes `dac_code` by exactly one toward the target, and it never passes the target.
- R6: Once `dac_code` equals a nonzero target it holds that value until a different target is written.
- R7: A write made while active, whether ramping or holding, redirects the ramp from the present code. The next step lands on the existing step grid, including a step on the same edge as the write, and the timer is not restarted.
- R8: With a zero target the code ramps down. `boost_en` falls and `shutdown` rises in exactly the cycle `dac_code` becomes 0, and never earlier.
- R9: A zero target written while active with `dac_code` already 0 puts the block into shutdown at the edge that samples the write.
- R10: `dac_code` changes only at an edge where `boost_en` was high before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for a new target |
| wr_code | input | CODE_W | Brightness target written with `wr_en` |
| rate_sel | input | RATE_W | Step rate select, interval = PRESCALE × 2^rate_sel clocks |
| dac_code | output | CODE_W | Live current DAC code |
| boost_en | output | 1 | Boost converter enable |
| shutdown | output | 1 | High while the driver is in shutdown |

## Verification
Each write is sampled at one edge, called W. A boost-enable rise, or a shutdown caused by a zero target with the code already at zero, appears at edge W itself. Code steps appear at the edges A + m·PRESCALE·2^rate_sel, where A is the edge that left shutdown. The first such step falls at or after W, or strictly after W when the write itself left shutdown. The driver task works out those edge numbers from a cycle counter and queues them. It discards any pending items when a redirecting write arrives. The monitor samples on the falling clock edge, pops one item per output change, and compares the edge number as well as the values. A change with nothing queued, or a queued edge that passes with no change, is counted as a failure.

// File: rtl/ledramp_pkg.sv
package ledramp_pkg;

    typedef enum logic [1:0] {
        RS_OFF  = 2'd0,
        RS_UP   = 2'd1,
        RS_DOWN = 2'd2,
        RS_HOLD = 2'd3
    } ramp_state_e;

endpackage

// File: rtl/ledramp_prescale.sv
module ledramp_prescale #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;

    // Counter is cleared while the driver is off so the step grid starts at activation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/ledramp_interval.sv
module ledramp_interval #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              step
);
    localparam int MAX_IVL = 1 << ((1 << RATE_W) - 1);
    localparam int IW      = (MAX_IVL > 1) ? $clog2(MAX_IVL) : 1;

    logic [IW:0]   ivl;
    logic [IW-1:0] ivl_m1;
    logic [IW-1:0] cnt_q;

    always_comb begin
        ivl    = (IW + 1)'(1) << rate_sel;
        ivl_m1 = IW'(ivl - (IW + 1)'(1));
    end

    assign step = tick && (cnt_q >= ivl_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + IW'(1);
        end
    end
endmodule

// File: rtl/ledramp_ctrl.sv
module ledramp_ctrl
    import ledramp_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int RATE_W   = 2,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [CODE_W-1:0] dac_code,
    output logic              boost_en,
    output logic              shutdown
);
    ramp_state_e       state_q, state_n;
    logic [CODE_W-1:0] code_q, code_n;
    logic [CODE_W-1:0] target_q, tgt_n;
    logic              run, tick, step;

    assign run = (state_q != RS_OFF);

    ledramp_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    ledramp_interval #(.RATE_W(RATE_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .rate_sel(rate_sel),
        .step    (step)
    );

    // Next target, next code and next state.
    always_comb begin
        tgt_n   = wr_en ? wr_code : target_q;
        code_n  = code_q;
        state_n = state_q;
        unique case (state_q)
            RS_OFF: begin
                if (wr_en && (wr_code != '0)) state_n = RS_UP;
            end
            RS_UP, RS_DOWN, RS_HOLD: begin
                if (step) begin
                    if (code_q < tgt_n)      code_n = code_q + CODE_W'(1);
                    else if (code_q > tgt_n) code_n = code_q - CODE_W'(1);
                end
                if (code_n == tgt_n)     state_n = (tgt_n == '0) ? RS_OFF : RS_HOLD;
                else if (code_n < tgt_n) state_n = RS_UP;
                else                     state_n = RS_DOWN;
            end
            default: state_n = RS_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RS_OFF;
            code_q   <= '0;
            target_q <= '0;
        end else begin
            state_q  <= state_n;
            code_q   <= code_n;
            target_q <= tgt_n;
        end
    end

    // Outputs.
    always_comb begin
        dac_code = code_q;
        boost_en = (state_q != RS_OFF);
        shutdown = (state_q == RS_OFF);
    end
endmodule

// File: rtl/ledramp_ctrl_chk.sv
module ledramp_ctrl_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              boost_en,
    input logic              shutdown,
    input logic [CODE_W-1:0] target_q
);
    assert_step_one_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == $past(dac_code)) ||
        ({1'b0, dac_code} == {1'b0, $past(dac_code)} + (CODE_W + 1)'(1)) ||
        ({1'b0, dac_code} + (CODE_W + 1)'(1) == {1'b0, $past(dac_code)}));

    assert_no_overshoot_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code > $past(dac_code)) |-> (dac_code <= target_q));

    assert_no_overshoot_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code < $past(dac_code)) |-> (dac_code >= target_q));

    assert_boost_off_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boost_en) |-> (dac_code == '0));

    assert_shutdown_code_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (dac_code == '0));

    assert_boost_on_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en) |-> $past(wr_en && (wr_code != '0)));

    assert_code_moves_when_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> $past(boost_en));
endmodule

bind ledramp_ctrl ledramp_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .dac_code(dac_code),
    .boost_en(boost_en),
    .shutdown(shutdown),
    .target_q(target_q)
);

// File: tb/tb_ledramp_ctrl.sv
module tb_ledramp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam int CW         = 6;

    typedef struct {
        int    cyc;
        int    code;
        bit    boost;
        string req;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_code = '0;
    logic [1:0]    rate_sel = '0;
    logic [CW-1:0] dac_code;
    logic          boost_en;
    logic          shutdown;

    exp_item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    mon_code = 0;
    bit    mon_boost = 1'b0;
    int    act_cyc = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string quiet_req = "R1";
    int    prev_code = 0;
    bit    prev_boost = 1'b0;
    bit    prev_shdn = 1'b1;

    ledramp_ctrl #(.CODE_W(CW), .RATE_W(2), .PRESCALE(PRE)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .rate_sel(rate_sel),
        .dac_code(dac_code),
        .boost_en(boost_en),
        .shutdown(shutdown)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input int code, input bit b, input string req);
        exp_item_t it;
        it.cyc = c; it.code = code; it.boost = b; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: pops one expected item per output change and compares cycle and values.
    always @(negedge clk) begin
        if (mon_en) begin
            if (int'(dac_code) != prev_code || boost_en != prev_boost || shutdown != prev_shdn) begin
                if (q.size() == 0) begin
                    check(1'b0, quiet_req, "unexpected output change, code", int'(dac_code), mon_code);
                end else begin
                    exp_item_t it;
                    it = q.pop_front();
                    check(cyc == it.cyc, it.req, "change cycle", cyc, it.cyc);
                    check(int'(dac_code) == it.code, it.req, "dac_code", int'(dac_code), it.code);
                    check(boost_en == it.boost, it.req, "boost_en", int'(boost_en), int'(it.boost));
                    check(shutdown == !it.boost, it.req, "shutdown", int'(shutdown), int'(!it.boost));
                    mon_code  = it.code;
                    mon_boost = it.boost;
                end
            end else if (q.size() > 0 && q[0].cyc < cyc) begin
                exp_item_t it;
                it = q.pop_front();
                check(1'b0, it.req, "missed change at cycle", cyc, it.cyc);
                mon_code  = it.code;
                mon_boost = it.boost;
            end
            prev_code  = int'(dac_code);
            prev_boost = boost_en;
            prev_shdn  = shutdown;
        end
    end

    // Driver: issues one write and queues every output change it implies.
    task automatic write_target(input int val, input int rate, input string req);
        int  w, c, t, e;
        bit  b;
        @(negedge clk);
        #1;
        w = cyc + 1;
        q.delete();
        c = mon_code;
        b = mon_boost;
        t = PRE << rate;
        rate_sel = 2'(rate);
        wr_code  = CW'(val);
        wr_en    = 1'b1;
        quiet_req = req;
        if (!b) begin
            if (val != 0) begin
                act_cyc = w;
                push(w, 0, 1'b1, "R2");
                b = 1'b1;
            end
        end else if (c == 0 && val == 0) begin
            push(w, 0, 1'b0, "R9");
        end
        if (b && c != val) begin
            if (w == act_cyc) e = w + t;
            else e = act_cyc + ((w - act_cyc + t - 1) / t) * t;
            while (c != val) begin
                c = (val > c) ? c + 1 : c - 1;
                push(e, c, !(c == 0 && val == 0), (c == 0 && val == 0) ? "R8" : req);
                e += t;
            end
        end
        @(negedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic settle(input int extra, input string req);
        while (q.size() != 0) @(negedge clk);
        quiet_req = req;
        repeat (extra) @(negedge clk);
        check(int'(dac_code) == mon_code, req, "settled dac_code", int'(dac_code), mon_code);
        check(boost_en == mon_boost, req, "settled boost_en", int'(boost_en), int'(mon_boost));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dac_code == '0, "R1", "reset dac_code", int'(dac_code), 0);
        check(boost_en == 1'b0, "R1", "reset boost_en", int'(boost_en), 0);
        check(shutdown == 1'b1, "R1", "reset shutdown", int'(shutdown), 1);
        rst_n = 1'b1;
        @(negedge clk);
        prev_code = int'(dac_code); prev_boost = boost_en; prev_shdn = shutdown;
        mon_en = 1'b1;

        // R3: zero written in shutdown is ignored
        write_target(0, 0, "R3");
        settle(30, "R3");

        // R2, R4, R5, R6: rise at rate 0, then hold
        write_target(5, 0, "R5");
        settle(40, "R6");

        // R7: new lower target written from hold, timer not restarted
        write_target(2, 0, "R7");
        settle(20, "R6");

        // R8: ramp to shutdown
        write_target(0, 0, "R8");
        settle(20, "R8");

        // R4, R7: rate 2, reversal in the middle of a rise
        write_target(10, 2, "R4");
        repeat (53) @(negedge clk);
        write_target(1, 2, "R7");
        settle(40, "R6");
        write_target(0, 2, "R8");
        settle(20, "R8");

        // R4, R5: slowest rate to full scale and back
        write_target(63, 3, "R4");
        settle(10, "R6");
        write_target(0, 3, "R8");
        settle(20, "R8");

        // R9: zero written before the first step
        write_target(3, 1, "R2");
        write_target(0, 1, "R9");
        settle(30, "R9");

        // R10: quiet in shutdown with rate 1
        write_target(0, 1, "R10");
        settle(20, "R10");

        check(q.size() == 0, "R5", "leftover expected items", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d (run did not finish)", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule